// File: doc/BRIEF.md
# Card Clock Divider with Bypass and Idle Gating

This block derives the clock for a memory-card bus from the master clock of the host controller. A single control word sets how the clock is made. An 8-bit divide value N gives a card clock of master/(2*(N+1)), and the output is high for exactly half of each period. A bypass bit passes the master clock straight through. An enable bit allows any clock to run at all. A power-save bit stops the clock while neither the command path nor the data path reports activity.

Besides the card clock, the block produces an advance strobe. The strobe is high for one master cycle at each rising edge of the card clock, so the command and data engines can step in the master domain without sampling the divided clock. The block also drives a wide-bus indication, taken from the same word, that selects 4-bit data transfers in place of 1-bit transfers.

Software loads the control word through one write port. A new divide value waits for the next toggle of the divided output, so a rewrite never shortens a phase that is already under way.

Top module: `cardclk_gen`

## Requirements
- R1: Control word fields are: bits [7:0] hold the divide value N, bit 8 is enable, bit 9 is bypass, bit 10 is power save and bit 11 is wide bus. With enable set and bypass clear, the card clock has a period of 2*(N+1) master cycles. It is high for N+1 cycles and low for N+1 cycles.
- R2: The advance strobe is high for exactly one master cycle per card-clock period, in the first master cycle in which the divided card clock is high.
- R3: While the enable bit is clear, the card clock is held low and the advance strobe stays low. This holds from the second master edge after the write that clears the bit.
- R4: With enable and bypass both set, the card clock follows the master clock and the divide field has no effect. The advance strobe is high in every master cycle. This holds from the second master edge after the write.
- R5: With power save set, the card clock and the strobe stop low while both busy inputs are low, and the clock runs again once either busy input is high. With power save clear, the busy inputs have no effect.
- R6: The wide-bus output equals bit 11 of the last written word, from the master edge that captures the write.
- R7: A divide value written while the clock runs takes effect only at the next toggle of the card clock. The phase in progress completes with its old length.
- R8: While reset is asserted, the card clock, the strobe and the wide-bus output are low, and the control word is cleared.
- R9: The divide range extends to both ends: N = 0 gives a period of 2 master cycles, and N = 255 gives 512, the slowest clock available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads wr_data into the control word on this edge |
| wr_data | input | 12 | Control word: divide [7:0], enable 8, bypass 9, power save 10, wide 11 |
| cmd_busy | input | 1 | Command path active |
| dat_busy | input | 1 | Data path active |
| card_clk | output | 1 | Clock to the card |
| clk_adv | output | 1 | One-cycle strobe at each rising card-clock edge |
| wide_bus | output | 1 | Selects 4-bit data mode when high |

## Verification
Two events can fall in the same cycle: a software write of a new divide value and the divider's own reload at a toggle. If they were handled wrong, the phase already under way would be cut short. The bench lands a write inside a running high phase. It then checks that this phase keeps the old length and that the following phases take the new one. The checker compares every completed high phase with the divide value held across it.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  parameter int DIV_W = 8;

  typedef struct packed {
    logic             wide;
    logic             psave;
    logic             byp;
    logic             en;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // length of one phase of the divided clock, in master cycles
  function automatic int unsigned phase_len(input logic [DIV_W-1:0] d);
    return int'(d) + 1;
  endfunction
endpackage

// File: rtl/cardclk_ctrl_reg.sv
module cardclk_ctrl_reg
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  ctrl_t            wr_word,
  output ctrl_t            ctrl_q,
  output logic [DIV_W-1:0] div_nxt
);
  ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = wr_en ? wr_word : ctrl_q;
    div_nxt  = ctrl_nxt.div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate
  import cardclk_pkg::*;
(
  input  ctrl_t ctrl_q,
  input  logic  cmd_busy,
  input  logic  dat_busy,
  output logic  run_div,
  output logic  byp_run
);
  logic bus_idle;
  logic idle_stop;

  always_comb begin
    bus_idle  = !cmd_busy && !dat_busy;
    idle_stop = ctrl_q.psave && bus_idle;
    run_div   = ctrl_q.en && !ctrl_q.byp && !idle_stop;
    byp_run   = ctrl_q.en &&  ctrl_q.byp && !idle_stop;
  end
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_nxt,
  output logic             div_clk,
  output logic [DIV_W-1:0] div_lim,
  output logic             rise_evt
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  always_comb begin
    hit      = run && (cnt == div_lim);
    rise_evt = hit && !div_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_clk <= 1'b0;
      div_lim <= '0;
    end else if (!run) begin
      cnt     <= '0;
      div_clk <= 1'b0;
      div_lim <= div_nxt;
    end else if (hit) begin
      cnt     <= '0;
      div_clk <= !div_clk;
      div_lim <= div_nxt;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  output logic              card_clk,
  output logic              clk_adv,
  output logic              wide_bus
);
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] div_lim;
  logic             run_div;
  logic             byp_run;
  logic             div_clk;
  logic             rise_evt;
  logic             byp_gate;

  cardclk_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (ctrl_t'(wr_data)),
    .ctrl_q  (ctrl_q),
    .div_nxt (div_nxt)
  );

  cardclk_gate u_gate (
    .ctrl_q   (ctrl_q),
    .cmd_busy (cmd_busy),
    .dat_busy (dat_busy),
    .run_div  (run_div),
    .byp_run  (byp_run)
  );

  cardclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_div),
    .div_nxt  (div_nxt),
    .div_clk  (div_clk),
    .div_lim  (div_lim),
    .rise_evt (rise_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_gate <= 1'b0;
      clk_adv  <= 1'b0;
    end else begin
      byp_gate <= byp_run;
      clk_adv  <= rise_evt || byp_run;
    end
  end

  assign card_clk = byp_gate ? clk : div_clk;
  assign wide_bus = ctrl_q.wide;
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk
  import cardclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_wide,
  input logic             cmd_busy,
  input logic             dat_busy,
  input logic             clk_adv,
  input logic             wide_bus,
  input logic             en_q,
  input logic             psave_q,
  input logic             div_clk,
  input logic [DIV_W-1:0] div_lim,
  input logic             run_div,
  input logic             byp_gate
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (div_clk) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_clk) && $past(run_div)) |-> (hi_cnt == ({1'b0, $past(div_lim)} + 1'b1)));

  assert_adv_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> clk_adv);

  assert_adv_only_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_adv && !byp_gate) |-> $rose(div_clk));

  assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!div_clk && !clk_adv && !byp_gate));

  assert_bypass_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byp_gate |-> !div_clk);

  assert_idle_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && psave_q && !cmd_busy && !dat_busy) |=> (!div_clk && !clk_adv));

  assert_wide_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wide_bus == $past(wr_wide)));
endmodule

bind cardclk_gen cardclk_gen_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_wide  (wr_data[cardclk_pkg::CTRL_W-1]),
  .cmd_busy (cmd_busy),
  .dat_busy (dat_busy),
  .clk_adv  (clk_adv),
  .wide_bus (wide_bus),
  .en_q     (ctrl_q.en),
  .psave_q  (ctrl_q.psave),
  .div_clk  (div_clk),
  .div_lim  (div_lim),
  .run_div  (run_div),
  .byp_gate (byp_gate)
);

// File: tb/cardclk_gen_tb_top.sv
module cardclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam int GUARD = 2000;
  // control words: divide [7:0], enable 8, bypass 9, power save 10, wide 11
  localparam logic [11:0] VEC_WORD [NVEC] = '{12'h100, 12'h101, 12'h903, 12'h107, 12'h9FF};
  localparam int          VEC_HALF [NVEC] = '{1, 2, 4, 8, 256};
  localparam logic        VEC_WIDE [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic        cmd_busy = 1'b0;
  logic        dat_busy = 1'b0;
  logic        card_clk;
  logic        clk_adv;
  logic        wide_bus;

  int checks = 0;
  int errors = 0;

  cardclk_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cmd_busy (cmd_busy),
    .dat_busy (dat_busy),
    .card_clk (card_clk),
    .clk_adv  (clk_adv),
    .wide_bus (wide_bus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [11:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // measures one high and one low phase, starting at a rising edge
  task automatic measure(output int hi, output int lo, output int adv_n, output int adv_first);
    logic prev;
    int   g;
    prev = card_clk;
    g = 0;
    hi = -1; lo = -1; adv_n = 0; adv_first = 0;
    forever begin
      @(negedge clk);
      g++;
      if (!prev && card_clk) break;
      prev = card_clk;
      if (g > GUARD) return;
    end
    adv_first = int'(clk_adv);
    adv_n = int'(clk_adv);
    hi = 1;
    forever begin
      @(negedge clk);
      adv_n += int'(clk_adv);
      if (!card_clk) break;
      hi++;
      if (hi > GUARD) return;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (card_clk) break;
      adv_n += int'(clk_adv);
      lo++;
      if (lo > GUARD) return;
    end
  endtask

  task automatic expect_quiet(input string req, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (card_clk || clk_adv) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, adv_n, adv_first;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 card_clk in reset", int'(card_clk), 0);
    check("R8 clk_adv in reset", int'(clk_adv), 0);
    check("R8 wide_bus in reset", int'(wide_bus), 0);
    rst_n = 1'b1;
    expect_quiet("R8 quiet after reset", 8);

    // table walk: R1, R2, R6, R9
    for (int v = 0; v < NVEC; v++) begin
      write_word(VEC_WORD[v]);
      check("R6 wide_bus after write", int'(wide_bus), int'(VEC_WIDE[v]));
      measure(hi, lo, adv_n, adv_first);
      measure(hi, lo, adv_n, adv_first);
      check("R1 R9 high phase", hi, VEC_HALF[v]);
      check("R1 R9 low phase", lo, VEC_HALF[v]);
      check("R2 strobes per period", adv_n, 1);
      check("R2 strobe on first high cycle", adv_first, 1);
    end

    // R3: clearing enable stops the clock
    write_word(12'h003);
    @(negedge clk);
    expect_quiet("R3 disabled clock low", 20);

    // R4: bypass follows the master clock, divide ignored
    write_word(12'h305);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R4 bypass high phase", int'(card_clk), 1);
      @(negedge clk);
      #(CLK_PERIOD/4);
      check("R4 bypass low phase", int'(card_clk), 0);
      check("R4 bypass strobe", int'(clk_adv), 1);
    end

    // R7: rewrite during a running high phase
    write_word(12'h103);
    measure(hi, lo, adv_n, adv_first);
    begin
      logic prev;
      prev = card_clk;
      forever begin
        @(negedge clk);
        if (!prev && card_clk) break;
        prev = card_clk;
      end
    end
    wr_en = 1'b1;
    wr_data = 12'h101;
    hi = 1;
    @(negedge clk);
    wr_en = 1'b0;
    if (card_clk) hi++;
    while (card_clk && hi < GUARD) begin
      @(negedge clk);
      if (card_clk) hi++;
    end
    check("R7 phase in progress keeps old length", hi, 4);
    lo = 1;
    forever begin
      @(negedge clk);
      if (card_clk || lo > GUARD) break;
      lo++;
    end
    check("R7 next phase uses new length", lo, 2);
    measure(hi, lo, adv_n, adv_first);
    check("R7 new high phase", hi, 2);

    // R5: power save gating against the busy inputs
    cmd_busy = 1'b1;
    write_word(12'h502);
    measure(hi, lo, adv_n, adv_first);
    measure(hi, lo, adv_n, adv_first);
    check("R5 runs while command busy", hi, 3);
    cmd_busy = 1'b0;
    repeat (2) @(negedge clk);
    expect_quiet("R5 stopped while idle", 20);
    dat_busy = 1'b1;
    measure(hi, lo, adv_n, adv_first);
    check("R5 resumes on data busy", hi, 3);
    check("R5 resumes low phase", lo, 3);
    dat_busy = 1'b0;
    write_word(12'h102);
    measure(hi, lo, adv_n, adv_first);
    measure(hi, lo, adv_n, adv_first);
    check("R5 no effect without power save", hi, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule